// File: doc/BRIEF.md
# Sub-Warp Mask Packer

This block sits in the decode stage of a wide-warp SIMD core. A large warp holds `LANES*ROWS` threads, several times the SIMD width of the execution pipeline. The block takes the large warp's active mask and turns it into a series of SIMD-width sub-warps, one per cycle. It treats the mask as a grid with one column for each SIMD lane and one row for each group of `LANES` threads. For every sub-warp it looks down each column and takes the lowest row that still has a pending active thread. Each taken thread is cleared, and new sub-warps are formed until no thread is left. Sparse, divergent masks are therefore compacted into far fewer issue slots than a row-by-row walk would need.

Each sub-warp leaves the block as a lane mask plus one row index per lane. Lane `k` with row `r` means thread `r*LANES + k`. An unconditional branch needs no divided issue, so the block can bypass the search: it sends one beat that covers every column and retires the whole warp at once. The block raises `done` when a large warp has drained. That is the moment the front end may fetch the warp again after a conditional branch. A new mask is taken only when the previous one has fully drained.

Top module: `subwarp_packer`

## Requirements
- R1: Bit `r*LANES + c` of `in_mask` is the thread in row `r`, column `c`. A beat that sets lane `c` with row field `r` refers to exactly that thread.
- R2: Each beat takes at most one thread from each column, and that thread is the lowest-numbered pending row of the column. `out_lanes[c]` is set exactly when column `c` still has a pending thread. The row index for lane `c` sits in `out_rows[c*RW +: RW]`, with `RW = $clog2(ROWS)`. Every beat sets at least one lane.
- R3: Threads sent in a beat are removed from the pending set. Beats continue, one per accepted cycle, until no pending thread is left. A conditional warp therefore takes as many beats as its fullest column has active threads.
- R4: `out_last` is high on the final beat of a warp. `done` is high in the cycle that final beat is accepted, and `out_valid` is low in the following cycle.
- R5: An all-zero mask produces no beats, and `done` is high in the same cycle the mask is accepted.
- R6: When `in_uncond` is high at acceptance and the mask is nonzero, exactly one beat is sent. Its lane mask is the OR of each column, its rows are the lowest active row of each column, `out_last` is high, and the warp retires when that beat is accepted.
- R7: `in_ready` is high exactly when no thread is pending. While a warp drains, `in_valid` and `in_mask` have no effect on the beats.
- R8: While `out_valid` is high and `out_ready` is low, the block holds the beat: `out_valid`, `out_lanes` and `out_rows` stay unchanged.
- R9: After reset, `out_valid` and `done` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Large-warp mask offered |
| in_ready | output | 1 | Block is idle and accepts a mask |
| in_mask | input | LANES*ROWS | Active mask, bit r*LANES+c = row r, column c |
| in_uncond | input | 1 | Warp is at an unconditional branch (single-beat bypass) |
| out_valid | output | 1 | Sub-warp beat present |
| out_ready | input | 1 | Pipeline takes the beat |
| out_lanes | output | LANES | Sub-warp lane mask |
| out_rows | output | LANES*RW | Row index per lane |
| out_last | output | 1 | Beat is the final one of the warp |
| done | output | 1 | Warp fully drained in this cycle |

## Verification
On every cycle, the checker enforces the handshake rules. It confirms that no mask is accepted while a beat is pending and that a stalled beat holds its value. It also confirms that every beat sets at least one lane, that a non-final beat is followed by another, that `done` leaves the block idle, that an empty mask finishes at once, and that a bypassed warp yields a final beat. Some things only the directed scenarios can show. These are the exact lane and row contents of each beat, the choice of the lowest row in each column, the beat count for a given mask, and the fact that a mask offered while busy leaves the sequence untouched. The bench compares those against a grid walk of its own.

// File: rtl/swp_pkg.sv
package swp_pkg;
  // thread number of the grid cell at (row, lane)
  function automatic int unsigned thread_of(int unsigned row, int unsigned lane,
                                            int unsigned lanes);
    return row * lanes + lane;
  endfunction

  // width of a row index for a grid of the given height
  function automatic int unsigned row_bits(int unsigned rows);
    return (rows < 2) ? 1 : $clog2(rows);
  endfunction
endpackage

// File: rtl/swp_col_pick.sv
module swp_col_pick #(
  parameter int ROWS = 4,
  localparam int RW = swp_pkg::row_bits(ROWS)
) (
  input  logic [ROWS-1:0] col_bits,
  output logic            found,
  output logic [RW-1:0]   idx,
  output logic [ROWS-1:0] hot
);
  always_comb begin
    idx = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (col_bits[r]) idx = r[RW-1:0];
    end
    found = |col_bits;
    hot   = found ? (ROWS'(1) << idx) : '0;
  end
endmodule

// File: rtl/swp_pend_reg.sv
module swp_pend_reg #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] load_val,
  input  logic         upd,
  input  logic [N-1:0] upd_val,
  output logic [N-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (upd)  q <= upd_val;
  end
endmodule

// File: rtl/subwarp_packer.sv
module subwarp_packer #(
  parameter int LANES = 4,
  parameter int ROWS  = 4,
  localparam int N  = LANES * ROWS,
  localparam int RW = swp_pkg::row_bits(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [N-1:0]     in_mask,
  input  logic             in_uncond,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [LANES-1:0] out_lanes,
  output logic [LANES*RW-1:0] out_rows,
  output logic             out_last,
  output logic             done
);
  logic [N-1:0]    pend_q;
  logic [N-1:0]    pick_mask;
  logic [N-1:0]    remaining;
  logic [N-1:0]    next_pend;
  logic            uncond_q;
  logic            in_fire;
  logic            beat_fire;
  logic            warp_drained;
  logic            empty_accept;

  logic [ROWS-1:0] col_bits [LANES];
  logic [ROWS-1:0] col_hot  [LANES];
  logic [RW-1:0]   col_idx  [LANES];
  logic            col_found[LANES];

  for (genvar c = 0; c < LANES; c++) begin : g_col
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign col_bits[c][r] = pend_q[swp_pkg::thread_of(r, c, LANES)];
      assign pick_mask[swp_pkg::thread_of(r, c, LANES)] = col_hot[c][r];
    end
    swp_col_pick #(.ROWS(ROWS)) u_pick (
      .col_bits (col_bits[c]),
      .found    (col_found[c]),
      .idx      (col_idx[c]),
      .hot      (col_hot[c])
    );
    assign out_lanes[c]           = col_found[c];
    assign out_rows[c*RW +: RW]   = col_idx[c];
  end

  assign in_ready     = ~|pend_q;
  assign out_valid    = |pend_q;
  assign in_fire      = in_valid & in_ready;
  assign beat_fire    = out_valid & out_ready;
  assign remaining    = pend_q & ~pick_mask;
  assign out_last     = out_valid & (uncond_q | ~|remaining);
  assign empty_accept = in_fire & ~|in_mask;
  assign warp_drained = beat_fire & out_last;
  assign done         = warp_drained | empty_accept;
  assign next_pend    = uncond_q ? '0 : remaining;

  swp_pend_reg #(.N(N)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (in_fire),
    .load_val (in_mask),
    .upd      (beat_fire),
    .upd_val  (next_pend),
    .q        (pend_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       uncond_q <= 1'b0;
    else if (in_fire) uncond_q <= in_uncond;
  end
endmodule

// File: rtl/swp_checker.sv
module swp_checker #(
  parameter int LANES = 4,
  parameter int ROWS  = 4,
  localparam int N  = LANES * ROWS,
  localparam int RW = swp_pkg::row_bits(ROWS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [N-1:0]     in_mask,
  input logic             in_uncond,
  input logic             out_valid,
  input logic             out_ready,
  input logic [LANES-1:0] out_lanes,
  input logic [LANES*RW-1:0] out_rows,
  input logic             out_last,
  input logic             done
);
  p_busy_blocks_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_stall_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_lanes) && $stable(out_rows));

  p_beat_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_lanes != '0);

  p_more_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid);

  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !out_valid);

  p_done_on_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && out_valid |-> out_ready && out_last);

  p_empty_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_mask == '0 |-> done);

  p_bypass_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_uncond && in_mask != '0 |=> out_valid && out_last);
endmodule

bind subwarp_packer swp_checker #(.LANES(LANES), .ROWS(ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_mask(in_mask), .in_uncond(in_uncond), .out_valid(out_valid),
  .out_ready(out_ready), .out_lanes(out_lanes), .out_rows(out_rows),
  .out_last(out_last), .done(done)
);

// File: tb/sim_subwarp_packer.sv
`timescale 1ns/1ps
module sim_subwarp_packer;
  localparam int LANES = 4;
  localparam int ROWS  = 4;
  localparam int N  = LANES * ROWS;
  localparam int RW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [N-1:0] in_mask = '0;
  logic in_uncond = 1'b0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_last, done;
  logic [LANES-1:0] out_lanes;
  logic [LANES*RW-1:0] out_rows;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  subwarp_packer #(.LANES(LANES), .ROWS(ROWS)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mask(in_mask), .in_uncond(in_uncond), .out_valid(out_valid),
    .out_ready(out_ready), .out_lanes(out_lanes), .out_rows(out_rows),
    .out_last(out_last), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Drive one large warp and compare each beat with an independent grid walk.
  task automatic run_warp(input logic [N-1:0] m, input bit unc, input bit stall,
                          input bit poke, input string req);
    logic [N-1:0] pend;
    logic [LANES-1:0] e_lanes;
    logic [LANES*RW-1:0] e_rows;
    bit e_last;
    @(negedge clk);
    chk(in_ready == 1'b1, "R7", "idle ready", in_ready, 1);
    in_valid = 1'b1; in_mask = m; in_uncond = unc; out_ready = 1'b1;
    #1;
    if (m == '0) chk(done == 1'b1, "R5", "empty done", done, 1);
    @(posedge clk);
    @(negedge clk);
    if (poke) begin in_mask = '1; in_uncond = 1'b0; end
    else in_valid = 1'b0;
    pend = m;
    while (pend != '0) begin
      e_lanes = '0; e_rows = '0;
      for (int c = 0; c < LANES; c++) begin
        for (int r = ROWS - 1; r >= 0; r--) begin
          if (pend[r*LANES + c]) begin
            e_lanes[c] = 1'b1;
            e_rows[c*RW +: RW] = RW'(r);
          end
        end
        if (e_lanes[c]) pend[int'(e_rows[c*RW +: RW])*LANES + c] = 1'b0;
      end
      if (unc) pend = '0;
      e_last = (pend == '0);
      if (stall) begin
        out_ready = 1'b0;
        #1;
        chk(in_ready == 1'b0, "R7", "busy not ready", in_ready, 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R8", "stalled valid", out_valid, 1);
        chk(out_lanes == e_lanes, "R8", "stalled lanes", out_lanes, e_lanes);
        out_ready = 1'b1;
      end
      #1;
      chk(out_valid == 1'b1, req, "valid", out_valid, 1);
      chk(out_lanes == e_lanes, req, "lanes", out_lanes, e_lanes);
      chk(out_rows == e_rows, req, "rows", out_rows, e_rows);
      chk(out_last == e_last, "R4", "last", out_last, e_last);
      chk(done == e_last, "R4", "done", done, e_last);
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_uncond = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R4", "idle after drain", out_valid, 0);
    chk(in_ready == 1'b1, "R7", "ready after drain", in_ready, 1);
  endtask

  task automatic t_reset();
    #1;
    chk(out_valid == 1'b0, "R9", "reset valid", out_valid, 0);
    chk(in_ready == 1'b1, "R9", "reset ready", in_ready, 1);
    chk(done == 1'b0, "R9", "reset done", done, 0);
  endtask

  task automatic t_single_thread();  // R1: thread 9 = row 2, column 1
    run_warp(16'h0200, 1'b0, 1'b0, 1'b0, "R1");
  endtask

  task automatic t_full();           // R3: full grid takes ROWS beats
    run_warp(16'hFFFF, 1'b0, 1'b0, 1'b0, "R3");
  endtask

  task automatic t_sparse();         // R2: divergent rows compact into two beats
    run_warp(16'h2498, 1'b0, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_one_column();     // R3: one column, four beats
    run_warp(16'h8888, 1'b0, 1'b0, 1'b0, "R3");
  endtask

  task automatic t_empty();          // R5
    run_warp(16'h0000, 1'b0, 1'b0, 1'b0, "R5");
  endtask

  task automatic t_bypass();         // R6
    run_warp(16'h8421 | 16'h0F00, 1'b1, 1'b0, 1'b0, "R6");
  endtask

  task automatic t_stall();          // R8
    run_warp(16'h5A3C, 1'b0, 1'b1, 1'b0, "R8");
  endtask

  task automatic t_busy_ignore();    // R7: offers during drain have no effect
    run_warp(16'h1248, 1'b0, 1'b0, 1'b1, "R7");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_single_thread();
    t_full();
    t_sparse();
    t_one_column();
    t_empty();
    t_bypass();
    t_stall();
    t_busy_ignore();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule